// File: doc/BRIEF.md
# Auto-Negotiation Arbitration Controller

This block carries out the link-code-word stage of twisted-pair auto-negotiation. At reset it loads the local technology advertisement from a 3-bit strap. It loads the enable from a second strap, and that strap also decides whether software may change the enable. Decoded link code words arrive from a fast-link-pulse receiver as strobes. Idle-detect flags arrive from the 10 Mb/s and 100 Mb/s receivers. The block tells the pulse transmitter when to send pulses and when to set the acknowledge bit.

In the ability phase, the block waits for three consecutive identical words and ignores the acknowledge bit when it compares them. It stores the word as the partner's ability and moves to the acknowledge phase. That phase needs three consecutive identical words that all carry the acknowledge bit. The block then picks the highest technology that both sides advertise and reports the speed and duplex. If the partner sends plain idle, the block takes half duplex at the detected speed. Three events restart negotiation: a failure (no common technology, or a timeout), a software restart, and a loss of link.

Top module: `an_arbiter`

## Requirements
- R1: At reset the advertisement `adv_bits` loads from `strap_tech` = n. Bit i is set exactly when n > i. The bit order is 0 = 10 Mb/s half, 1 = 10 Mb/s full, 2 = 100 Mb/s half, 3 = 100 Mb/s full, so 3'b001 gives 4'b0001 and 3'b111 gives 4'b1111. In a link code word these four bits sit at word positions 5, 6, 7 and 8.
- R2: A write on `adv_wr` can clear advertisement bits (new = old AND `adv_wdata`) and can never set one.
- R3: `an_en` resets to `strap_an_en`. A write on `ctrl_wr` loads `ctrl_an_en` only when the strap is high; when the strap is low the write is ignored and `an_en` stays 0.
- R4: While enabled, `flp_tx_en` rises one cycle after reset. It also rises after `link_lost` in link, and after a restart. It is low while the link is up and while the block is disabled.
- R5: In the ability or acknowledge phase, `idle_100` (which wins over `idle_10`) brings the link up one cycle later at half duplex, with `speed100` set to the detected speed.
- R6: In the ability phase, three consecutive words that are equal with bit 14 (acknowledge) masked are accepted. `lp_word` takes the third word and `tx_ack` rises on the next cycle. A word that differs from the previous one restarts the run at one.
- R7: In the acknowledge phase, three consecutive identical words with bit 14 set bring up the link at the highest common technology, in the order 100 full, 100 half, 10 full, 10 half. The result reads as `speed100`/`full_dup`. A word without bit 14 clears the run.
- R8: A completed acknowledge run with no common technology, or TIMEOUT cycles spent in negotiation since it last began, sets `an_fault` and restarts the ability phase. `an_fault` clears when a link comes up or on a restart.
- R9: Writing `ctrl_restart` = 1 makes `restart_bit` read 1 for exactly one cycle. Negotiation then restarts in the ability phase.
- R10: When a completed acknowledge run and an idle flag arrive in the same cycle, the negotiated result is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_tech | input | 3 | Technology strap, sampled in reset |
| strap_an_en | input | 1 | Enable strap: default and write permission |
| adv_wr | input | 1 | Advertisement write strobe |
| adv_wdata | input | 4 | Advertisement write data (AND mask) |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_an_en | input | 1 | Enable value written |
| ctrl_restart | input | 1 | Restart request written |
| rx_word_vld | input | 1 | Received link code word strobe |
| rx_word | input | 16 | Received link code word |
| idle_10 | input | 1 | Partner 10 Mb/s idle detected |
| idle_100 | input | 1 | Partner 100 Mb/s idle detected |
| link_lost | input | 1 | Loss of link indication |
| adv_bits | output | 4 | Local advertisement readback |
| an_en | output | 1 | Enable readback |
| restart_bit | output | 1 | Restart bit readback (self-clearing) |
| lp_word | output | 16 | Stored partner word |
| flp_tx_en | output | 1 | Send link pulses |
| tx_ack | output | 1 | Set acknowledge in sent words |
| link_up | output | 1 | Link configured |
| speed100 | output | 1 | Resolved speed is 100 Mb/s |
| full_dup | output | 1 | Resolved duplex is full |
| an_fault | output | 1 | Negotiation failure status |

## Verification
The acknowledge run can finish in the same cycle that an idle flag arrives, so the negotiated path and the parallel-detect path compete. The bench sends the third acknowledged word together with `idle_100`, using an advertisement limited to 10 Mb/s half. A correct result is 10 Mb/s half duplex; 100 Mb/s half would show that the idle path won. A behavioural model compares every output on every cycle, including the failure-and-restart sequence.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int WORD_W   = 16;
  localparam int NTECH    = 4;
  localparam int TECH_LSB = 5;
  localparam int ACK_POS  = 14;
  localparam logic [WORD_W-1:0] ACK_MASK = WORD_W'(1) << ACK_POS;

  typedef enum logic [1:0] {ST_IDLE, ST_ABIL, ST_ACK, ST_LINK} an_state_t;

  // strap value n advertises the n lowest technologies
  function automatic logic [NTECH-1:0] strap_to_adv(input logic [2:0] s);
    logic [NTECH-1:0] a;
    for (int i = 0; i < NTECH; i++) a[i] = (int'(s) > i);
    return a;
  endfunction

  // {found, index of highest common technology}
  function automatic logic [2:0] best_tech(input logic [NTECH-1:0] c);
    logic [2:0] r;
    r = 3'b000;
    for (int i = 0; i < NTECH; i++)
      if (c[i]) r = {1'b1, 2'(i)};
    return r;
  endfunction
endpackage

// File: rtl/an_adv_regs.sv
module an_adv_regs
  import an_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       strap_tech,
  input  logic             strap_an_en,
  input  logic             adv_wr,
  input  logic [NTECH-1:0] adv_wdata,
  input  logic             ctrl_wr,
  input  logic             ctrl_an_en,
  input  logic             ctrl_restart,
  output logic [NTECH-1:0] adv_bits,
  output logic             an_en,
  output logic             restart_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_bits    <= strap_to_adv(strap_tech);
      an_en       <= strap_an_en;
      restart_bit <= 1'b0;
    end else begin
      if (adv_wr) adv_bits <= adv_bits & adv_wdata;
      if (ctrl_wr && strap_an_en) an_en <= ctrl_an_en;
      restart_bit <= ctrl_wr && ctrl_restart;
    end
  end

  assert_adv_never_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_bits & ~$past(adv_bits)) == '0);
  assert_en_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_an_en |-> !an_en);
  assert_restart_from_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_bit |-> $past(ctrl_wr && ctrl_restart));
endmodule

// File: rtl/an_word_match.sv
module an_word_match
  import an_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int THRESH = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         vld,
  input  logic [W-1:0] word,
  input  logic         ack_phase,
  output logic         hit
);
  localparam int CW = $clog2(THRESH + 1);
  localparam logic [W-1:0] MASK = W'(ACK_MASK);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  prev_q;
  logic          qual, same;

  assign qual = ack_phase ? word[ACK_POS] : 1'b1;
  assign same = ack_phase ? (word == prev_q) : (((word ^ prev_q) & ~MASK) == '0);
  assign hit  = vld && qual && same && (cnt_q == CW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (vld) begin
      prev_q <= word;
      if (!qual)                        cnt_q <= '0;
      else if (cnt_q != '0 && same)     cnt_q <= cnt_q + 1'b1;
      else                              cnt_q <= CW'(1);
    end
  end

  assert_run_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(THRESH));
endmodule

// File: rtl/an_arbiter.sv
module an_arbiter
  import an_pkg::*;
#(
  parameter int TIMEOUT = 100000,
  parameter int MATCH_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_tech,
  input  logic              strap_an_en,
  input  logic              adv_wr,
  input  logic [NTECH-1:0]  adv_wdata,
  input  logic              ctrl_wr,
  input  logic              ctrl_an_en,
  input  logic              ctrl_restart,
  input  logic              rx_word_vld,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              idle_10,
  input  logic              idle_100,
  input  logic              link_lost,
  output logic [NTECH-1:0]  adv_bits,
  output logic              an_en,
  output logic              restart_bit,
  output logic [WORD_W-1:0] lp_word,
  output logic              flp_tx_en,
  output logic              tx_ack,
  output logic              link_up,
  output logic              speed100,
  output logic              full_dup,
  output logic              an_fault
);
  localparam int TW = $clog2(TIMEOUT + 1);

  an_state_t   st_q, st_n;
  logic [TW-1:0] tmr_q;
  logic        active, hit, clr_run;
  logic        go_abil, fail, neg_done, pd_take;
  logic [2:0]  best;

  an_adv_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strap_tech(strap_tech), .strap_an_en(strap_an_en),
    .adv_wr(adv_wr), .adv_wdata(adv_wdata), .ctrl_wr(ctrl_wr),
    .ctrl_an_en(ctrl_an_en), .ctrl_restart(ctrl_restart),
    .adv_bits(adv_bits), .an_en(an_en), .restart_bit(restart_bit)
  );

  assign active = (st_q == ST_ABIL) || (st_q == ST_ACK);

  an_word_match #(.W(WORD_W), .THRESH(MATCH_N)) u_match (
    .clk(clk), .rst_n(rst_n), .clr(clr_run), .vld(rx_word_vld && active),
    .word(rx_word), .ack_phase(st_q == ST_ACK), .hit(hit)
  );

  assign best = best_tech(adv_bits & rx_word[TECH_LSB +: NTECH]);

  always_comb begin
    st_n = st_q; go_abil = 1'b0; fail = 1'b0; neg_done = 1'b0; pd_take = 1'b0;
    if (!an_en) begin
      st_n = ST_IDLE;
    end else if (restart_bit) begin
      st_n = ST_ABIL; go_abil = 1'b1;
    end else begin
      case (st_q)
        ST_IDLE: begin st_n = ST_ABIL; go_abil = 1'b1; end
        ST_ABIL, ST_ACK: begin
          if (hit) begin
            if (st_q == ST_ABIL)  st_n = ST_ACK;
            else if (best[2])     begin st_n = ST_LINK; neg_done = 1'b1; end
            else                  begin st_n = ST_ABIL; fail = 1'b1; go_abil = 1'b1; end
          end else if (idle_100 || idle_10) begin
            st_n = ST_LINK; pd_take = 1'b1;
          end else if (tmr_q == TW'(TIMEOUT - 1)) begin
            st_n = ST_ABIL; fail = 1'b1; go_abil = 1'b1;
          end
        end
        default: if (link_lost) begin st_n = ST_ABIL; go_abil = 1'b1; end
      endcase
    end
  end

  assign clr_run = (st_n != st_q) || go_abil;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      tmr_q    <= '0;
      lp_word  <= '0;
      speed100 <= 1'b0;
      full_dup <= 1'b0;
      an_fault <= 1'b0;
    end else begin
      st_q <= st_n;
      if (go_abil || !(st_n == ST_ABIL || st_n == ST_ACK)) tmr_q <= '0;
      else                                                 tmr_q <= tmr_q + 1'b1;
      if (hit) lp_word <= rx_word;
      if (neg_done) begin
        speed100 <= best[1];
        full_dup <= best[0];
      end else if (pd_take) begin
        speed100 <= idle_100;
        full_dup <= 1'b0;
      end
      if (fail)                                          an_fault <= 1'b1;
      else if (neg_done || pd_take || (an_en && restart_bit)) an_fault <= 1'b0;
    end
  end

  assign flp_tx_en = active;
  assign tx_ack    = (st_q == ST_ACK);
  assign link_up   = (st_q == ST_LINK);

  assert_pd_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_take |=> link_up && !full_dup);
  assert_res_common_R7: assert property (@(posedge clk) disable iff (!rst_n)
    neg_done |=> link_up && lp_word[TECH_LSB + 2*int'(speed100) + int'(full_dup)]);
  assert_fault_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(an_fault) |-> flp_tx_en && !tx_ack);
  assert_quiet_in_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(link_up && !link_lost && an_en && !restart_bit) |-> !flp_tx_en);
endmodule

// File: tb/tb_an_arbiter.sv
module tb_an_arbiter;
  localparam int TMO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] strap_tech = 3'b111;
  logic strap_an_en = 1'b1;
  logic adv_wr = 0, ctrl_wr = 0, ctrl_an_en = 0, ctrl_restart = 0;
  logic [3:0] adv_wdata = 0;
  logic rx_word_vld = 0, idle_10 = 0, idle_100 = 0, link_lost = 0;
  logic [15:0] rx_word = 0;
  logic [3:0] adv_bits;
  logic an_en, restart_bit, flp_tx_en, tx_ack, link_up, speed100, full_dup, an_fault;
  logic [15:0] lp_word;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  an_arbiter #(.TIMEOUT(TMO), .MATCH_N(3)) dut (
    .clk(clk), .rst_n(rst_n), .strap_tech(strap_tech), .strap_an_en(strap_an_en),
    .adv_wr(adv_wr), .adv_wdata(adv_wdata), .ctrl_wr(ctrl_wr), .ctrl_an_en(ctrl_an_en),
    .ctrl_restart(ctrl_restart), .rx_word_vld(rx_word_vld), .rx_word(rx_word),
    .idle_10(idle_10), .idle_100(idle_100), .link_lost(link_lost),
    .adv_bits(adv_bits), .an_en(an_en), .restart_bit(restart_bit), .lp_word(lp_word),
    .flp_tx_en(flp_tx_en), .tx_ack(tx_ack), .link_up(link_up), .speed100(speed100),
    .full_dup(full_dup), .an_fault(an_fault)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase;          // 0 off, 1 ability, 2 acknowledge, 3 link
  bit [3:0] m_adv;
  bit m_en, m_rs, m_fault, m_spd, m_full;
  bit [15:0] m_lp;
  int m_wait;
  bit [15:0] runq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_rs = 0; m_fault = 0; m_spd = 0; m_full = 0; m_lp = 0; m_wait = 0;
      runq.delete();
      m_en = strap_an_en;
      for (int i = 0; i < 4; i++) m_adv[i] = (int'(strap_tech) > i);
    end else begin
      bit got, restart_go, clear_run;
      int nxt;
      bit [15:0] w;
      bit [3:0] common;
      got = 0; restart_go = 0; nxt = m_phase; w = rx_word;
      if (rx_word_vld && (m_phase == 1 || m_phase == 2)) begin
        if (m_phase == 2 && !w[14]) runq.delete();
        else begin
          if (runq.size() > 0) begin
            bit [15:0] d;
            d = runq[$] ^ w;
            if (m_phase == 1) d[14] = 0;
            if (d != 0) runq.delete();
          end
          runq.push_back(w);
          got = (runq.size() == 3);
        end
      end
      if (!m_en) nxt = 0;
      else if (m_rs) begin nxt = 1; restart_go = 1; m_fault = 0; end
      else if (m_phase == 0) begin nxt = 1; restart_go = 1; end
      else if (m_phase == 3) begin if (link_lost) begin nxt = 1; restart_go = 1; end end
      else if (got) begin
        m_lp = w;
        common = m_adv & w[8:5];
        if (m_phase == 1) nxt = 2;
        else if (common == 0) begin nxt = 1; restart_go = 1; m_fault = 1; end
        else begin
          nxt = 3; m_fault = 0;
          if (common[3])      begin m_spd = 1; m_full = 1; end
          else if (common[2]) begin m_spd = 1; m_full = 0; end
          else if (common[1]) begin m_spd = 0; m_full = 1; end
          else                begin m_spd = 0; m_full = 0; end
        end
      end
      else if (idle_100 || idle_10) begin nxt = 3; m_spd = idle_100; m_full = 0; m_fault = 0; end
      else if (m_wait == TMO - 1) begin nxt = 1; restart_go = 1; m_fault = 1; end
      clear_run = (nxt != m_phase) || restart_go;
      if (clear_run || got) runq.delete();
      if (restart_go || !(nxt == 1 || nxt == 2)) m_wait = 0; else m_wait++;
      m_phase = nxt;
      if (adv_wr) m_adv = m_adv & adv_wdata;
      if (ctrl_wr && strap_an_en) m_en = ctrl_an_en;
      m_rs = ctrl_wr && ctrl_restart;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n && cyc > 1) begin
      chk(adv_bits == m_adv, "R1/R2 adv", adv_bits, m_adv);
      chk(an_en == m_en, "R3 an_en", an_en, m_en);
      chk(restart_bit == m_rs, "R9 restart_bit", restart_bit, m_rs);
      chk(flp_tx_en == (m_phase == 1 || m_phase == 2), "R4 flp", flp_tx_en, m_phase);
      chk(tx_ack == (m_phase == 2), "R6 tx_ack", tx_ack, m_phase);
      chk(lp_word == m_lp, "R6 lp_word", lp_word, m_lp);
      chk(link_up == (m_phase == 3), "R7 link_up", link_up, m_phase);
      if (m_phase == 3)
        chk({speed100, full_dup} == {m_spd, m_full}, "R7 speed/duplex",
            {speed100, full_dup}, {m_spd, m_full});
      chk(an_fault == m_fault, "R8 fault", an_fault, m_fault);
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [15:0] w, input bit i100 = 0);
    @(negedge clk); rx_word_vld = 1; rx_word = w; idle_100 = i100;
    @(negedge clk); rx_word_vld = 0; idle_100 = 0;
  endtask
  task automatic send3(input logic [15:0] w);
    repeat (3) send(w);
  endtask
  task automatic wr_adv(input logic [3:0] d);
    @(negedge clk); adv_wr = 1; adv_wdata = d;
    @(negedge clk); adv_wr = 0;
  endtask
  task automatic wr_ctrl(input bit en, input bit rs);
    @(negedge clk); ctrl_wr = 1; ctrl_an_en = en; ctrl_restart = rs;
    @(negedge clk); ctrl_wr = 0; ctrl_restart = 0;
  endtask
  task automatic lose_link();
    @(negedge clk); link_lost = 1;
    @(negedge clk); link_lost = 0;
  endtask
  task automatic do_reset(input logic [2:0] t, input bit e);
    @(negedge clk); rst_n = 0; strap_tech = t; strap_an_en = e;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(adv_bits == 4'hF, "R1 strap 111", adv_bits, 4'hF);
    chk(an_en == 1'b1, "R3 strap high default", an_en, 1);
    @(negedge clk);
    chk(flp_tx_en, "R4 pulses after reset", flp_tx_en, 1);

    send3(16'h01E1);
    chk(tx_ack && lp_word == 16'h01E1, "R6 ability accepted", lp_word, 16'h01E1);
    send3(16'h41E1);
    chk(link_up && speed100 && full_dup, "R7 100 full", {speed100, full_dup}, 3);

    lose_link();
    chk(flp_tx_en && !link_up, "R4 loss of link", flp_tx_en, 1);

    wr_adv(4'b0111);
    wr_adv(4'b1111);
    chk(adv_bits == 4'b0111, "R2 no set", adv_bits, 4'b0111);

    send(16'h0061); send(16'h0061); send(16'h00E1); send(16'h00E1);
    chk(!tx_ack, "R6 mismatch restarts run", tx_ack, 0);
    send(16'h00E1);
    chk(tx_ack, "R6 run after mismatch", tx_ack, 1);
    send(16'h40E1); send(16'h00E1); send(16'h40E1); send(16'h40E1);
    chk(tx_ack && !link_up, "R7 missing ack clears run", link_up, 0);
    send(16'h40E1);
    chk(link_up && speed100 && !full_dup, "R7 100 half", {speed100, full_dup}, 2);

    wr_ctrl(1, 1);
    chk(restart_bit, "R9 restart reads 1", restart_bit, 1);
    @(negedge clk);
    chk(!restart_bit && flp_tx_en, "R9 self-clear and restart", restart_bit, 0);

    wr_adv(4'b0001);
    send3(16'h0181); send3(16'h4181);
    chk(an_fault && flp_tx_en && !tx_ack, "R8 no common", an_fault, 1);

    wr_ctrl(1, 1);
    @(negedge clk);
    chk(!an_fault, "R8 fault cleared by restart", an_fault, 0);
    repeat (20) @(negedge clk);
    chk(!an_fault, "R8 before timeout", an_fault, 0);
    repeat (22) @(negedge clk);
    chk(an_fault && flp_tx_en, "R8 timeout", an_fault, 1);

    @(negedge clk); idle_100 = 1; idle_10 = 1;
    @(negedge clk); idle_100 = 0; idle_10 = 0;
    chk(link_up && speed100 && !full_dup && !an_fault, "R5 100 idle", {speed100, full_dup}, 2);
    lose_link();
    @(negedge clk); idle_10 = 1;
    @(negedge clk); idle_10 = 0;
    chk(link_up && !speed100 && !full_dup, "R5 10 idle", {speed100, full_dup}, 0);

    lose_link();
    send3(16'h0021); send(16'h4021); send(16'h4021); send(16'h4021, 1'b1);
    chk(link_up && !speed100 && !full_dup, "R10 negotiated beats idle", speed100, 0);

    wr_ctrl(0, 0);
    @(negedge clk);
    chk(!an_en && !link_up && !flp_tx_en, "R3 disable", an_en, 0);

    do_reset(3'b001, 1'b0);
    @(negedge clk);
    chk(adv_bits == 4'b0001, "R1 strap 001", adv_bits, 1);
    chk(!an_en && !flp_tx_en, "R3 strap low default", an_en, 0);
    wr_ctrl(1, 0);
    chk(!an_en, "R3 write ignored", an_en, 0);

    do_reset(3'b010, 1'b1);
    @(negedge clk);
    chk(adv_bits == 4'b0011, "R1 strap 010", adv_bits, 3);
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule